// File: doc/BRIEF.md
# Stream-to-Memory DMA Engine

This block is a single-channel direct memory access engine that sits inside a peripheral, such as an audio capture front end. It drains a stream of device words into system memory without help from the processor. Software programs a physical start address and a byte length through a small register port. It then writes a command word that arms the transfer. From then on the engine emits one memory write per device word. Each write carries an address that advances by the word size. The engine stops when the length is used up or when memory reports a fault.

The engine records the outcome in sticky done and error flags. Software clears these flags by writing a 1 to them. An interrupt line is driven from the two flags, gated by an interrupt-enable bit taken from the command word. Addresses go out exactly as programmed. The engine performs no address translation.

Top module: `strm_dma`

## Requirements
- R1: After reset the status register (index 3) reads 0, `irq` is low, and both `mem_valid` and `src_ready` are low.
- R2: A transfer starts only on a write to the command register (index 2) made while idle with bit 0 (go), bit 1 (interrupt enable) and bit 2 (input direction) all set. Any other command value starts nothing.
- R3: Every device word taken on `src_valid`/`src_ready` becomes exactly one memory write, in arrival order. `mem_valid`, `mem_addr` and `mem_data` hold steady until `mem_ready` is high.
- R4: The first write goes to the base register (index 0). Each accepted write adds 4 to the address and takes 4 from the length register (index 1). Both registers read back this progress.
- R5: On the clock edge that accepts the last write, status bit 0 (busy) clears and status bit 1 (done) sets.
- R6: A start command whose length is zero, whose length is not a multiple of 4, or whose base is not 4-byte aligned sets status bit 2 (error) and issues no write.
- R7: `irq` equals (done OR error) AND the interrupt-enable bit. That bit is loaded from command bit 1 on every command write made while idle.
- R8: Writing 1 to status bit 1 or bit 2 clears that flag. A successful start clears both flags.
- R9: If `mem_err` is high on an accepted write, the transfer aborts: busy clears and error sets. The base and length registers stay at the values of the failing word.
- R10: While busy, writes to the base, length and command registers have no effect.
- R11: `reg_rdata` shows the register selected by `reg_sel` one clock edge after the selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index: 0 base, 1 length, 2 command, 3 status |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Registered read data of the selected register |
| src_valid | input | 1 | Device word available |
| src_data | input | DW | Device word |
| src_ready | output | 1 | Engine takes the device word this edge |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | AW | Physical byte address of the write |
| mem_data | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the write this edge |
| mem_err | input | 1 | Fault response, qualified by `mem_ready` |
| irq | output | 1 | Completion/error interrupt |

## Verification
A register write takes effect on the clock edge after its strobe. A read returns data one edge after `reg_sel` changes. So the bench samples register results only after those edges have passed. A memory write is due one edge after its device word is taken. Done or error, and with them `irq`, appear on the same edge that accepts the last or faulting write. The bench therefore samples each result between the falling edge and the next rising edge, after that edge has occurred. A scoreboard holds the expected address and data of every write. It compares each write at the cycle it is accepted, so a lost, extra or reordered write shows up at once. Polls of the interrupt are bounded and count as failures when they expire.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int CMD_GO  = 0;
  localparam int CMD_IE  = 1;
  localparam int CMD_IN  = 2;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int RW = 32,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [RW-1:0] reg_wdata,
  input  logic          busy,
  input  logic [AW-1:0] cur_addr,
  input  logic [CW-1:0] remain,
  input  logic          done_q,
  input  logic          err_q,
  output logic          base_we,
  output logic          len_we,
  output logic          start,
  output logic          clr_done,
  output logic          clr_err,
  output logic          irq_en,
  output logic [RW-1:0] reg_rdata
);
  logic          wr_idle;
  logic          cmd_we;
  logic          stat_we;
  logic [RW-1:0] rd_mux;
  logic          wdata_unused;

  assign wdata_unused = ^reg_wdata;
  assign wr_idle  = reg_we && !busy;
  assign base_we  = wr_idle && (reg_sel == SEL_BASE);
  assign len_we   = wr_idle && (reg_sel == SEL_LEN);
  assign cmd_we   = wr_idle && (reg_sel == SEL_CMD);
  assign stat_we  = reg_we && (reg_sel == SEL_STAT);
  assign start    = cmd_we && reg_wdata[CMD_GO] && reg_wdata[CMD_IE] && reg_wdata[CMD_IN];
  assign clr_done = stat_we && reg_wdata[ST_DONE];
  assign clr_err  = stat_we && reg_wdata[ST_ERR];

  always_comb begin
    rd_mux = '0;
    case (reg_sel)
      SEL_BASE: rd_mux[AW-1:0] = cur_addr;
      SEL_LEN:  rd_mux[CW-1:0] = remain;
      SEL_CMD:  rd_mux[CMD_IE] = irq_en;
      default: begin
        rd_mux[ST_BUSY] = busy;
        rd_mux[ST_DONE] = done_q;
        rd_mux[ST_ERR]  = err_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (cmd_we) irq_en <= reg_wdata[CMD_IE];
      reg_rdata <= rd_mux;
    end
  end

  // R11
  rd_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == SEL_STAT) |=> (reg_rdata[ST_BUSY] == $past(busy)));
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq #(
  parameter int RW = 32,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_we,
  input  logic          len_we,
  input  logic          start,
  input  logic [RW-1:0] wdata,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          mem_valid,
  output logic [DW-1:0] mem_data,
  output logic          busy,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] remain,
  output logic          done_set,
  output logic          err_set
);
  localparam int STEP = DW / 8;
  localparam int ALB  = $clog2(STEP);

  logic cfg_bad;
  logic accept;
  logic last_beat;

  assign cfg_bad   = (remain == '0) || (remain[ALB-1:0] != '0) || (cur_addr[ALB-1:0] != '0);
  assign accept    = mem_valid && mem_ready;
  assign last_beat = (remain == CW'(STEP));
  assign done_set  = accept && !mem_err && last_beat;
  assign err_set   = (start && cfg_bad) || (accept && mem_err);
  assign src_ready = busy && !mem_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      mem_valid <= 1'b0;
      mem_data  <= '0;
      cur_addr  <= '0;
      remain    <= '0;
    end else begin
      if (base_we) cur_addr <= wdata[AW-1:0];
      if (len_we)  remain   <= wdata[CW-1:0];
      if (start && !cfg_bad) busy <= 1'b1;
      if (src_ready && src_valid) begin
        mem_valid <= 1'b1;
        mem_data  <= src_data;
      end
      if (accept) begin
        mem_valid <= 1'b0;
        if (mem_err) begin
          busy <= 1'b0;
        end else begin
          cur_addr <= cur_addr + AW'(STEP);
          remain   <= remain - CW'(STEP);
          if (last_beat) busy <= 1'b0;
        end
      end
    end
  end

  // R3
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data) && $stable(cur_addr)));
  // R3
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy);
  // R2
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R4
  len_live_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (remain != '0));
endmodule

// File: rtl/sdma_irq.sv
module sdma_irq (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done_set,
  input  logic err_set,
  input  logic clr_done,
  input  logic clr_err,
  input  logic irq_en,
  output logic done_q,
  output logic err_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (done_set)                done_q <= 1'b1;
      else if (start || clr_done)  done_q <= 1'b0;
      if (err_set)                 err_q  <= 1'b1;
      else if (start || clr_err)   err_q  <= 1'b0;
    end
  end

  assign irq = (done_q || err_q) && irq_en;

  // R8
  clr_done_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_done && !done_set) |=> !done_q);
endmodule

// File: rtl/strm_dma.sv
module strm_dma #(
  parameter int RW = 32,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          irq
);
  logic          busy, done_q, err_q, irq_en;
  logic          base_we, len_we, start, clr_done, clr_err;
  logic          done_set, err_set;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] remain;

  sdma_regs #(.RW(RW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .cur_addr(cur_addr), .remain(remain), .done_q(done_q), .err_q(err_q),
    .base_we(base_we), .len_we(len_we), .start(start), .clr_done(clr_done),
    .clr_err(clr_err), .irq_en(irq_en), .reg_rdata(reg_rdata)
  );

  sdma_seq #(.RW(RW), .AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .base_we(base_we), .len_we(len_we), .start(start),
    .wdata(reg_wdata), .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .mem_ready(mem_ready), .mem_err(mem_err), .mem_valid(mem_valid), .mem_data(mem_data),
    .busy(busy), .cur_addr(cur_addr), .remain(remain), .done_set(done_set), .err_set(err_set)
  );

  sdma_irq u_irq (
    .clk(clk), .rst(rst), .start(start), .done_set(done_set), .err_set(err_set),
    .clr_done(clr_done), .clr_err(clr_err), .irq_en(irq_en),
    .done_q(done_q), .err_q(err_q), .irq(irq)
  );

  assign mem_addr = cur_addr;

  // R5
  end_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done_q || err_q));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!src_ready && !mem_valid));
endmodule

// File: tb/strm_dma_bench.sv
module strm_dma_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_valid = 1'b0;
  logic [31:0] src_data;
  logic        src_ready;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_ready = 1'b0;
  logic        mem_err;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int beat_cnt = 0;
  int err_idx = -1;
  bit src_en = 1'b0;
  bit stall = 1'b0;
  bit src_take, mem_take;
  logic [31:0] src_word = 32'hA500_0000;
  logic [7:0]  lfsr = 8'h5B;
  logic [63:0] exp_q[$];
  logic [31:0] rd;

  always #5 clk = ~clk;

  assign src_data = src_word;
  assign mem_err  = mem_ready && (beat_cnt == err_idx);

  strm_dma u_strm_dma (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .mem_err(mem_err), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // stimulus update just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (src_take) src_word++;
    if (mem_take) beat_cnt++;
    src_valid = src_en && (cyc % 5 != 3);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = !stall && (lfsr[0] || lfsr[1]);
  end

  // scoreboard monitor, samples between falling and rising edge
  always @(negedge clk) begin
    #2;
    src_take = src_valid && src_ready;
    mem_take = mem_valid && mem_ready && !rst;
    if (mem_take) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected memory write", mem_addr, 32'h0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(mem_addr == e[63:32], "R4", "write address", mem_addr, e[63:32]);
        chk(mem_data == e[31:0], "R3", "write data", mem_data, e[31:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not end", 32'(cyc), 32'd0);
    finish_run();
  end

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] data);
    @(posedge clk); #1;
    reg_sel = sel;
    @(posedge clk); #2;
    data = reg_rdata;
  endtask

  task automatic expect_beats(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back({base + 32'(4 * i), src_word + 32'(i)});
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk); #3;
      n++;
    end
    chk(irq == 1'b1, req, "interrupt reached", {31'd0, irq}, 32'd1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #3;
    // R1 reset state
    chk(irq == 1'b0, "R1", "irq after reset", {31'd0, irq}, 32'd0);
    chk(!mem_valid && !src_ready, "R1", "handshakes idle", {30'd0, mem_valid, src_ready}, 32'd0);
    reg_read(2'd3, rd);
    chk(rd == 32'd0, "R1", "status after reset", rd, 32'd0);

    // R3 R4 R5: normal transfer of 8 words
    src_en = 1'b1;
    expect_beats(32'h1000, 8);
    reg_write(2'd0, 32'h1000);
    reg_write(2'd1, 32'd32);
    reg_write(2'd2, 32'd7);
    wait_irq("R7");
    chk(exp_q.size() == 0, "R3", "all words written", 32'(exp_q.size()), 32'd0);
    reg_read(2'd3, rd);
    chk(rd == 32'd2, "R5", "status after finish", rd, 32'd2);
    reg_read(2'd0, rd);
    chk(rd == 32'h1020, "R4", "base readback after finish", rd, 32'h1020);
    reg_read(2'd1, rd);
    chk(rd == 32'd0, "R4", "length readback after finish", rd, 32'd0);
    // R11 read selected register one edge later
    chk(rd == 32'd0, "R11", "length read latency", rd, 32'd0);

    // R8 write-one-to-clear done
    reg_write(2'd3, 32'd2);
    reg_read(2'd3, rd);
    chk(rd == 32'd0, "R8", "status after clearing done", rd, 32'd0);
    chk(irq == 1'b0, "R8", "irq after clearing done", {31'd0, irq}, 32'd0);

    // R2 incomplete command words start nothing
    reg_write(2'd0, 32'h2000);
    reg_write(2'd1, 32'd16);
    reg_write(2'd2, 32'd5);
    repeat (20) @(posedge clk);
    reg_read(2'd3, rd);
    chk(rd == 32'd0, "R2", "no start without interrupt enable", rd, 32'd0);
    reg_write(2'd2, 32'd3);
    repeat (20) @(posedge clk);
    reg_read(2'd3, rd);
    chk(rd == 32'd0, "R2", "no start without input bit", rd, 32'd0);
    reg_read(2'd1, rd);
    chk(rd == 32'd16, "R2", "length untouched", rd, 32'd16);

    // R6 bad configurations
    reg_write(2'd1, 32'd0);
    reg_write(2'd2, 32'd7);
    reg_read(2'd3, rd);
    chk(rd == 32'd4, "R6", "zero length error", rd, 32'd4);
    chk(irq == 1'b1, "R7", "irq on error", {31'd0, irq}, 32'd1);
    reg_write(2'd3, 32'd4);
    reg_write(2'd0, 32'h2002);
    reg_write(2'd1, 32'd16);
    reg_write(2'd2, 32'd7);
    reg_read(2'd3, rd);
    chk(rd == 32'd4, "R6", "misaligned base error", rd, 32'd4);
    reg_write(2'd3, 32'd4);
    reg_write(2'd0, 32'h2000);
    reg_write(2'd1, 32'd10);
    reg_write(2'd2, 32'd7);
    reg_read(2'd3, rd);
    chk(rd == 32'd4, "R6", "odd length error", rd, 32'd4);
    reg_write(2'd3, 32'd4);

    // R9 memory fault on the third write
    beat_cnt = 0;
    err_idx = 2;
    expect_beats(32'h3000, 3);
    reg_write(2'd0, 32'h3000);
    reg_write(2'd1, 32'd32);
    reg_write(2'd2, 32'd7);
    wait_irq("R9");
    err_idx = -1;
    chk(exp_q.size() == 0, "R9", "writes up to fault", 32'(exp_q.size()), 32'd0);
    reg_read(2'd3, rd);
    chk(rd == 32'd4, "R9", "status after fault", rd, 32'd4);
    reg_read(2'd1, rd);
    chk(rd == 32'd24, "R9", "length at fault", rd, 32'd24);
    reg_read(2'd0, rd);
    chk(rd == 32'h3008, "R9", "base at fault", rd, 32'h3008);
    reg_write(2'd3, 32'd4);

    // R10 writes ignored while busy (source held off)
    src_en = 1'b0;
    @(posedge clk);
    expect_beats(32'h4000, 4);
    reg_write(2'd0, 32'h4000);
    reg_write(2'd1, 32'd16);
    reg_write(2'd2, 32'd7);
    reg_write(2'd0, 32'h5550);
    reg_write(2'd1, 32'h40);
    reg_write(2'd2, 32'd0);
    reg_read(2'd3, rd);
    chk(rd == 32'd1, "R10", "busy while source idle", rd, 32'd1);
    reg_read(2'd0, rd);
    chk(rd == 32'h4000, "R10", "base write ignored", rd, 32'h4000);
    reg_read(2'd1, rd);
    chk(rd == 32'd16, "R10", "length write ignored", rd, 32'd16);
    reg_read(2'd2, rd);
    chk(rd == 32'd2, "R10", "command write ignored", rd, 32'd2);
    src_en = 1'b1;
    wait_irq("R10");
    chk(exp_q.size() == 0, "R10", "original transfer completed", 32'(exp_q.size()), 32'd0);
    reg_read(2'd0, rd);
    chk(rd == 32'h4010, "R10", "base after transfer", rd, 32'h4010);

    // R7 masking through the interrupt-enable bit
    reg_write(2'd2, 32'd0);
    @(negedge clk); #3;
    chk(irq == 1'b0, "R7", "irq masked", {31'd0, irq}, 32'd0);
    reg_read(2'd3, rd);
    chk(rd == 32'd2, "R7", "done kept while masked", rd, 32'd2);
    reg_write(2'd2, 32'd2);
    @(negedge clk); #3;
    chk(irq == 1'b1, "R7", "irq unmasked", {31'd0, irq}, 32'd1);

    // R8 start clears done; R3 backpressure
    stall = 1'b1;
    expect_beats(32'h6000, 4);
    reg_write(2'd0, 32'h6000);
    reg_write(2'd1, 32'd16);
    reg_write(2'd2, 32'd7);
    repeat (8) @(posedge clk);
    reg_read(2'd3, rd);
    chk(rd == 32'd1, "R8", "start cleared done", rd, 32'd1);
    chk(mem_valid == 1'b1, "R3", "request held under backpressure", {31'd0, mem_valid}, 32'd1);
    chk(irq == 1'b0, "R8", "irq low while running", {31'd0, irq}, 32'd0);
    stall = 1'b0;
    wait_irq("R5");
    chk(exp_q.size() == 0, "R3", "backpressured words written", 32'(exp_q.size()), 32'd0);

    finish_run();
  end
endmodule